// File: doc/BRIEF.md
# Indirect Memory Read Port

This block gives a host that only has a narrow byte-wide register bus a way to fetch full 32-bit words out of a 2048-word internal RAM. The host first sets a word address by writing two address registers, low byte then high byte. The write to the high byte is also the trigger: it starts one RAM read and drops a ready flag in a control register. The host polls that flag. When it reads back as 1, the fetched word can be read from four byte-wide data registers, least significant byte at the lowest offset.

Toward the RAM side the block has a request stream and a response stream. The request (`mem_req_valid` / `mem_req_ready`) follows valid/ready rules. Once `mem_req_valid` is raised, it stays high with `mem_req_addr` unchanged until a cycle in which `mem_req_ready` is also high, so the arbiter may apply back-pressure for any number of cycles. The block has at most one read in flight. It never stalls the response stream: a word offered with `mem_rsp_valid` is always taken in that same cycle, so that stream has no ready signal. The register port is plain. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current register state.

If the host starts a new read before the previous one has returned, the earlier word is thrown away and never reaches the data registers. Only the most recent address is delivered.

Top module: `ixrd_port`

## Requirements
- R1: After reset, the control register (offset 0x33) reads 0x01. Both address registers (0x34 low byte, 0x35 high byte) read 0x00, all four data registers read 0x00, and `mem_req_valid` is 0.
- R2: The address registers read back exactly the 8 bits last written, including the unused high bits of 0x35. The RAM word address is {0x35[2:0], 0x34[7:0]}, and bits 7:3 of 0x35 have no effect on it.
- R3: Every write to offset 0x35 launches exactly one new RAM request for the address formed from the written value and the current low byte, even when the written value equals the stored one.
- R4: In the cycle after a write to 0x35, bit 0 of the control register reads 0. Bits 7:1 of the control register always read 0.
- R5: When a response for the current address is accepted, the word is loaded into the data registers and ready returns to 1 at the same clock edge. 0x38 holds bits 7:0, 0x39 bits 15:8, 0x3A bits 23:16 and 0x3B bits 31:24.
- R6: The data registers keep their value until the next read completes, including the whole time a later read is outstanding.
- R7: If 0x35 is written while a read is still pending (waiting for grant or for data), the older result is discarded. Ready stays 0 until the word for the newest address arrives, and that word is what the data registers then hold.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with a stable address in the next cycle. At most one request is outstanding at a time.
- R9: Writes to the control register, to the data registers and to unmapped offsets change nothing, and unmapped offsets read 0x00. A write to 0x34 alone does not launch a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mem_req_valid | output | 1 | RAM read request valid |
| mem_req_ready | input | 1 | RAM read request accepted by arbiter |
| mem_req_addr | output | 11 | RAM word address of the request |
| mem_rsp_valid | input | 1 | RAM read data valid, always accepted |
| mem_rsp_data | input | 32 | RAM read data word |

## Verification
The bench goes after three hazards in particular.

- A second trigger while a read is in flight. It is applied both while the request waits for grant and after grant. A design that lets the stale word through would flash ready or end up holding the wrong word.
- A repeated write of the same high byte. A design that compares against the stored value would skip that launch and issue too few requests.
- Long grant and data latencies. These check that the old data is not overwritten early and that the request holds steady under back-pressure. A design that re-samples the address registers would send a changed address.

Writes to read-only and unmapped offsets, and writes to the low byte alone, are also checked so that none of them launches a read or alters the visible state.

// File: rtl/ixrd_pkg.sv
package ixrd_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_st_e;

endpackage

// File: rtl/ixrd_regfile.sv
module ixrd_regfile #(
  parameter int AW      = 11,
  parameter int DW      = 32,
  parameter int BW      = 8,
  parameter int RAW     = 8,
  parameter int OFS_CTL = 'h33,
  parameter int OFS_ALO = 'h34,
  parameter int OFS_AHI = 'h35,
  parameter int OFS_DAT = 'h38
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [RAW-1:0] addr_i,
  input  logic [BW-1:0]  wdata_i,
  output logic [BW-1:0]  rdata_o,
  input  logic           ready_i,
  input  logic [DW-1:0]  data_i,
  output logic           launch_o,
  output logic [AW-1:0]  launch_addr_o
);

  localparam int NB  = DW / BW;
  localparam int HIB = AW - BW;

  logic [BW-1:0] alo_q;
  logic [BW-1:0] ahi_q;
  logic          hit_alo;
  logic          hit_ahi;

  assign hit_alo = (addr_i == RAW'(OFS_ALO));
  assign hit_ahi = (addr_i == RAW'(OFS_AHI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0;
      ahi_q <= '0;
    end else if (wr_i) begin
      if (hit_alo) alo_q <= wdata_i;
      if (hit_ahi) ahi_q <= wdata_i;
    end
  end

  assign launch_o      = wr_i && hit_ahi;
  assign launch_addr_o = {wdata_i[HIB-1:0], alo_q};

  always_comb begin
    rdata_o = '0;
    if (addr_i == RAW'(OFS_CTL)) rdata_o = {{(BW-1){1'b0}}, ready_i};
    if (hit_alo) rdata_o = alo_q;
    if (hit_ahi) rdata_o = ahi_q;
    for (int i = 0; i < NB; i++) begin
      if (addr_i == RAW'(OFS_DAT + i)) rdata_o = data_i[i*BW +: BW];
    end
  end

  AST_AHI_HOLDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> (ahi_q == $past(wdata_i))); // R2

  AST_ALO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && hit_alo) |=> $stable(alo_q)); // R9

endmodule

// File: rtl/ixrd_fetch.sv
module ixrd_fetch
  import ixrd_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic [AW-1:0] launch_addr_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          deliver_o,
  output logic [DW-1:0] deliver_data_o
);

  fetch_st_e     st_q;
  logic          stale_q;
  logic [AW-1:0] pend_q;
  logic [AW-1:0] raddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      stale_q <= 1'b0;
      pend_q  <= '0;
      raddr_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          if (launch_i) begin
            raddr_q <= launch_addr_i;
            st_q    <= FS_REQ;
          end
        end
        FS_REQ: begin
          if (req_ready_i) st_q <= FS_WAIT;
          if (launch_i) begin
            stale_q <= 1'b1;
            pend_q  <= launch_addr_i;
          end
        end
        FS_WAIT: begin
          if (rsp_valid_i) begin
            if (stale_q || launch_i) begin
              raddr_q <= launch_i ? launch_addr_i : pend_q;
              stale_q <= 1'b0;
              st_q    <= FS_REQ;
            end else begin
              st_q <= FS_IDLE;
            end
          end else if (launch_i) begin
            stale_q <= 1'b1;
            pend_q  <= launch_addr_i;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign req_valid_o    = (st_q == FS_REQ);
  assign req_addr_o     = raddr_q;
  assign deliver_o      = (st_q == FS_WAIT) && rsp_valid_i && !stale_q && !launch_i;
  assign deliver_data_o = rsp_data_i;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o))); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> !req_valid_o); // R8

  AST_NO_DELIVER_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !deliver_o); // R7

endmodule

// File: rtl/ixrd_capture.sv
module ixrd_capture #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic          deliver_i,
  input  logic [DW-1:0] deliver_data_i,
  output logic          ready_o,
  output logic [DW-1:0] data_o
);

  localparam int NB = DW / BW;

  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ready_q <= 1'b1;
    else if (launch_i)  ready_q <= 1'b0;
    else if (deliver_i) ready_q <= 1'b1;
  end

  assign ready_o = ready_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lane_q <= '0;
      else if (deliver_i) lane_q <= deliver_data_i[g*BW +: BW];
    end
    assign data_o[g*BW +: BW] = lane_q;
  end

  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> !ready_o); // R4

  AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_i |=> (ready_o && (data_o == $past(deliver_data_i)))); // R5

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver_i |=> $stable(data_o)); // R6

endmodule

// File: rtl/ixrd_port.sv
module ixrd_port #(
  parameter int AW      = 11,
  parameter int DW      = 32,
  parameter int BW      = 8,
  parameter int RAW     = 8,
  parameter int OFS_CTL = 'h33,
  parameter int OFS_ALO = 'h34,
  parameter int OFS_AHI = 'h35,
  parameter int OFS_DAT = 'h38
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [BW-1:0]  reg_wdata,
  output logic [BW-1:0]  reg_rdata,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data
);

  logic          launch;
  logic [AW-1:0] launch_addr;
  logic          deliver;
  logic [DW-1:0] deliver_data;
  logic          ready;
  logic [DW-1:0] data;

  ixrd_regfile #(
    .AW(AW), .DW(DW), .BW(BW), .RAW(RAW),
    .OFS_CTL(OFS_CTL), .OFS_ALO(OFS_ALO), .OFS_AHI(OFS_AHI), .OFS_DAT(OFS_DAT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .ready_i(ready), .data_i(data),
    .launch_o(launch), .launch_addr_o(launch_addr)
  );

  ixrd_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch), .launch_addr_i(launch_addr),
    .req_valid_o(mem_req_valid), .req_ready_i(mem_req_ready), .req_addr_o(mem_req_addr),
    .rsp_valid_i(mem_rsp_valid), .rsp_data_i(mem_rsp_data),
    .deliver_o(deliver), .deliver_data_o(deliver_data)
  );

  ixrd_capture #(.DW(DW), .BW(BW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch), .deliver_i(deliver), .deliver_data_i(deliver_data),
    .ready_o(ready), .data_o(data)
  );

endmodule

// File: tb/sim_ixrd_port.sv
module sim_ixrd_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [10:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  ixrd_port u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // RAM model settings and observations
  int          gdly = 0;
  int          lat  = 0;
  int          hs_cnt = 0;
  logic [10:0] last_addr = '0;
  bit          hold_bad = 1'b0;

  function automatic logic [31:0] memf(input logic [10:0] a);
    return (32'h9E3779B1 * {21'd0, a}) ^ 32'h0F1E2D3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // RAM responder: all outputs change at negedge
  initial begin
    int          wcnt = 0;
    int          cnt  = 0;
    bit          busy = 1'b0;
    logic [10:0] haddr = '0;
    logic [10:0] seen = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (busy) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memf(haddr);
          busy = 1'b0;
        end else cnt--;
      end
      mem_req_ready = 1'b0;
      if (wcnt > 0 && (!mem_req_valid || mem_req_addr != seen)) hold_bad = 1'b1;
      if (mem_req_valid && !busy) begin
        if (wcnt < gdly) begin
          seen = mem_req_addr;
          wcnt++;
        end else begin
          mem_req_ready = 1'b1;
          haddr = mem_req_addr;
          last_addr = mem_req_addr;
          busy = 1'b1;
          cnt  = lat;
          wcnt = 0;
          hs_cnt++;
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    #2;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_word(output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(8'h38 + 8'(i), b);
      w[i*8 +: 8] = b;
    end
  endtask

  task automatic poll(output int n);
    logic [7:0] c;
    n = 0;
    do begin
      rd(8'h33, c);
      n++;
    end while (c != 8'h01 && n < 200);
  endtask

  // {addr_hi, addr_lo, grant delay, latency}
  localparam logic [23:0] VEC [8] = '{
    24'h01_23_0_0, 24'h07_FF_1_2, 24'hF8_00_0_5, 24'h05_5A_3_1,
    24'hAB_C4_2_7, 24'h00_01_0_3, 24'h7E_80_4_0, 24'h03_3C_1_9
  };

  initial begin
    logic [7:0]  b;
    logic [31:0] w, w0;
    logic [10:0] ea;
    int n, h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h33, b); chk(b == 8'h01, "R1 ctl", b, 8'h01);
    rd(8'h34, b); chk(b == 8'h00, "R1 alo", b, 0);
    rd(8'h35, b); chk(b == 8'h00, "R1 ahi", b, 0);
    rd_word(w);   chk(w == 0, "R1 data", w, 0);
    chk(mem_req_valid == 1'b0, "R1 req", mem_req_valid, 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      gdly = int'(VEC[v][7:4]);
      lat  = int'(VEC[v][3:0]);
      ea   = {VEC[v][18:16], VEC[v][15:8]};
      wr(8'h34, VEC[v][15:8]);
      wr(8'h35, VEC[v][23:16]);
      rd(8'h33, b); chk(b == 8'h00, "R4 ready cleared", b, 0);
      poll(n);
      chk(n < 200, "R5 ready returns", n, 0);
      rd_word(w); chk(w == memf(ea), "R5 data lanes", w, memf(ea));
      chk(last_addr == ea, "R3 request address", last_addr, ea);
      rd(8'h35, b); chk(b == VEC[v][23:16], "R2 ahi readback", b, VEC[v][23:16]);
      rd(8'h34, b); chk(b == VEC[v][15:8], "R2 alo readback", b, VEC[v][15:8]);
    end

    // R9 low byte alone does not launch; read-only and unmapped writes ignored
    gdly = 0; lat = 1;
    rd_word(w0);
    h0 = hs_cnt;
    wr(8'h34, 8'h11);
    wr(8'h33, 8'h00);
    wr(8'h38, 8'hEE);
    wr(8'h3B, 8'hEE);
    wr(8'h50, 8'h77);
    repeat (5) @(negedge clk);
    chk(hs_cnt == h0, "R9 no launch", hs_cnt, h0);
    rd(8'h33, b); chk(b == 8'h01, "R9 ctl kept", b, 1);
    rd_word(w);   chk(w == w0, "R9 data kept", w, w0);
    rd(8'h50, b); chk(b == 8'h00, "R9 unmapped read", b, 0);

    // R3 repeated identical write launches again
    wr(8'h35, 8'h02); poll(n);
    h0 = hs_cnt;
    wr(8'h35, 8'h02); poll(n);
    chk(hs_cnt == h0 + 1, "R3 repeat launch", hs_cnt, h0 + 1);
    rd_word(w); chk(w == memf(11'h211), "R3 repeat data", w, memf(11'h211));

    // R6 data held while a slow read is pending and after it completes
    w0 = w;
    lat = 20;
    wr(8'h35, 8'h04);
    repeat (8) @(negedge clk);
    rd_word(w); chk(w == w0, "R6 held during read", w, w0);
    rd(8'h33, b); chk(b == 8'h00, "R6 still busy", b, 0);
    poll(n);
    rd_word(w); chk(w == memf(11'h411), "R6 new data", w, memf(11'h411));
    repeat (10) @(negedge clk);
    rd_word(w0); chk(w0 == w, "R6 stable after", w0, w);

    // R7 retrigger after grant: stale word discarded
    lat = 6; gdly = 0;
    wr(8'h35, 8'h01);
    wr(8'h35, 8'h06);
    repeat (7) @(negedge clk);
    rd(8'h33, b); chk(b == 8'h00, "R7 ready low past stale word", b, 0);
    poll(n);
    rd_word(w); chk(w == memf(11'h611), "R7 newest after grant", w, memf(11'h611));

    // R7 retrigger while request awaits grant (R8 back-pressure)
    lat = 2; gdly = 5;
    wr(8'h35, 8'h03);
    wr(8'h35, 8'h05);
    poll(n);
    rd_word(w); chk(w == memf(11'h511), "R7 newest before grant", w, memf(11'h511));
    chk(last_addr == 11'h511, "R7 last request", last_addr, 11'h511);

    // R8 request held under back-pressure
    chk(!hold_bad, "R8 request stable", hold_bad, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule